// File: doc/BRIEF.md
# Intra Block Pixel Predictor

This block builds a square prediction block for a video encoder or decoder from pixels that have already been reconstructed around it. It takes the row of pixels above the block, the column of pixels to its left and the single pixel diagonally above-left, and forms a 4x4, 8x8 or 16x16 prediction using one of four modes. The modes are horizontal copy, vertical copy, a flat DC average and a gradient mode. The gradient mode adds the left and above neighbours, subtracts the corner and clamps the result to the pixel range.

A one-cycle start pulse latches the neighbours, the size and the mode. The block then streams the predicted pixels in raster order over a valid/ready handshake and flags the final pixel. Because the neighbour pixels are captured at start, the upstream logic may reuse its buses as soon as the start has been accepted. A start that arrives while a block is still streaming is ignored.

Top module: `intra_pred`

## Requirements
- R1: Size code 0 gives a 4x4 block, code 1 gives 8x8, and codes 2 and 3 give 16x16. Each block is exactly N*N accepted beats long.
- R2: Mode code 2 (horizontal) emits left[i] for every pixel of row i. Pixel k of the left bus sits at bits [8k+7:8k].
- R3: Mode code 1 (vertical) emits above[j] for every pixel of column j. Pixel k of the above bus sits at bits [8k+7:8k].
- R4: Mode code 0 (DC) emits, for every pixel, (sum of above[0..N-1] + sum of left[0..N-1] + N) >> log2(2N).
- R5: Mode code 3 (gradient) emits left[i] + above[j] - corner for each pixel. The value is computed with its sign and clamped to 0..255.
- R6: Pixels leave in raster order, row 0 first and columns ascending within a row. out_last is high only with the final pixel. The cycle after that pixel is accepted, out_valid is low.
- R7: While out_valid is high and out_ready is low, out_valid, out_pix and out_last hold their values.
- R8: A start pulse received while a block is in progress has no effect on that block's pixels or length.
- R9: Neighbour, size and mode inputs are captured on the accepted start. Changing them afterwards does not alter the block being emitted.
- R10: After synchronous reset, out_valid and out_last are low.
- R11: The first pixel is presented with out_valid high on the second rising edge after the edge that accepts start. out_valid is still low after the first of those edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new block when idle |
| size_sel | input | 2 | Block size code (0=4, 1=8, 2/3=16) |
| mode_sel | input | 2 | Prediction mode (0=DC, 1=V, 2=H, 3=gradient) |
| above | input | 128 | Above-row pixels, pixel k at [8k+7:8k] |
| left | input | 128 | Left-column pixels, pixel k at [8k+7:8k] |
| corner | input | 8 | Above-left pixel |
| out_ready | input | 1 | Consumer accepts the current pixel |
| out_valid | output | 1 | Output pixel is valid |
| out_pix | output | 8 | Predicted pixel |
| out_last | output | 1 | Final pixel of the block |

## Verification
After the edge that accepts start, out_valid stays low for exactly one cycle. The first pixel appears after the second edge, and every later pixel appears one edge after the previous one is accepted. The bench drives inputs on falling edges and samples on falling edges, so it checks out_valid low at the first falling edge after start and high at the second. It compares each pixel at the falling edge before the edge where ready accepts it, and it checks the hold condition at the falling edge that follows a refused beat. The cycle after the last acceptance is checked for out_valid low.

// File: rtl/intra_pred_pkg.sv
package intra_pred_pkg;
  typedef enum logic [1:0] {
    PM_DC   = 2'd0,
    PM_VERT = 2'd1,
    PM_HORZ = 2'd2,
    PM_GRAD = 2'd3
  } pred_mode_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PREP = 2'd1,
    ST_EMIT = 2'd2
  } pred_state_t;
endpackage

// File: rtl/ip_nbr_store.sv
module ip_nbr_store #(
  parameter int MAX_N = 16,
  parameter int PW    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [MAX_N*PW-1:0] above_i,
  input  logic [MAX_N*PW-1:0] left_i,
  input  logic [PW-1:0]       corner_i,
  output logic [MAX_N*PW-1:0] above_q,
  output logic [MAX_N*PW-1:0] left_q,
  output logic [PW-1:0]       corner_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      above_q  <= '0;
      left_q   <= '0;
      corner_q <= '0;
    end else if (load) begin
      above_q  <= above_i;
      left_q   <= left_i;
      corner_q <= corner_i;
    end
  end
endmodule

// File: rtl/ip_dc_calc.sv
module ip_dc_calc #(
  parameter int MAX_N = 16,
  parameter int PW    = 8,
  localparam int LG_MAX = $clog2(MAX_N),
  localparam int LG_W   = $clog2(LG_MAX + 2),
  localparam int NB_W   = LG_MAX + 1,
  localparam int SUM_W  = PW + LG_MAX + 1
) (
  input  logic [MAX_N*PW-1:0] above_q,
  input  logic [MAX_N*PW-1:0] left_q,
  input  logic [LG_W-1:0]     lg,
  input  logic [NB_W-1:0]     n_blk,
  output logic [PW-1:0]       dc
);
  logic [SUM_W-1:0] acc;
  logic [SUM_W-1:0] rounded;
  logic [SUM_W-1:0] shifted;

  always_comb begin
    acc = '0;
    for (int k = 0; k < MAX_N; k++) begin
      if (k < int'(n_blk)) begin
        acc = acc + SUM_W'(above_q[k*PW +: PW]) + SUM_W'(left_q[k*PW +: PW]);
      end
    end
    rounded = acc + SUM_W'(n_blk);
    shifted = rounded >> (lg + LG_W'(1));
    dc      = shifted[PW-1:0];
  end
endmodule

// File: rtl/ip_raster.sv
module ip_raster #(
  parameter int MAX_N = 16,
  localparam int IDX_W = $clog2(MAX_N),
  localparam int NB_W  = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             advance,
  input  logic [NB_W-1:0]  n_blk,
  output logic [IDX_W-1:0] row,
  output logic [IDX_W-1:0] col,
  output logic             at_end
);
  logic [NB_W-1:0]  lim_w;
  logic [IDX_W-1:0] lim;

  assign lim_w  = n_blk - NB_W'(1);
  assign lim    = lim_w[IDX_W-1:0];
  assign at_end = (row == lim) && (col == lim);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      row <= '0;
      col <= '0;
    end else if (advance) begin
      if (col == lim) begin
        col <= '0;
        row <= row + IDX_W'(1);
      end else begin
        col <= col + IDX_W'(1);
      end
    end
  end
endmodule

// File: rtl/ip_pix_gen.sv
module ip_pix_gen
  import intra_pred_pkg::*;
#(
  parameter int MAX_N = 16,
  parameter int PW    = 8,
  localparam int IDX_W = $clog2(MAX_N),
  localparam int EXT_W = PW + 2
) (
  input  pred_mode_t          mode,
  input  logic [IDX_W-1:0]    row,
  input  logic [IDX_W-1:0]    col,
  input  logic [MAX_N*PW-1:0] above_q,
  input  logic [MAX_N*PW-1:0] left_q,
  input  logic [PW-1:0]       corner_q,
  input  logic [PW-1:0]       dc,
  output logic [PW-1:0]       pix
);
  logic [PW-1:0]           a_j;
  logic [PW-1:0]           l_i;
  logic signed [EXT_W-1:0] grad;
  logic [PW-1:0]           grad_clamped;

  assign a_j = above_q[col*PW +: PW];
  assign l_i = left_q[row*PW +: PW];

  always_comb begin
    grad = $signed({2'b00, l_i}) + $signed({2'b00, a_j}) - $signed({2'b00, corner_q});
    if (grad < 0)
      grad_clamped = '0;
    else if (grad > $signed({2'b00, {PW{1'b1}}}))
      grad_clamped = {PW{1'b1}};
    else
      grad_clamped = grad[PW-1:0];
  end

  always_comb begin
    unique case (mode)
      PM_DC:   pix = dc;
      PM_VERT: pix = a_j;
      PM_HORZ: pix = l_i;
      default: pix = grad_clamped;
    endcase
  end
endmodule

// File: rtl/intra_pred.sv
module intra_pred
  import intra_pred_pkg::*;
#(
  parameter int MAX_N = 16,
  parameter int PW    = 8,
  localparam int LG_MAX = $clog2(MAX_N),
  localparam int LG_W   = $clog2(LG_MAX + 2),
  localparam int IDX_W  = LG_MAX,
  localparam int NB_W   = LG_MAX + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [1:0]          size_sel,
  input  logic [1:0]          mode_sel,
  input  logic [MAX_N*PW-1:0] above,
  input  logic [MAX_N*PW-1:0] left,
  input  logic [PW-1:0]       corner,
  input  logic                out_ready,
  output logic                out_valid,
  output logic [PW-1:0]       out_pix,
  output logic                out_last
);
  pred_state_t         st;
  pred_mode_t          mode_q;
  logic [LG_W-1:0]     lg_q;
  logic [LG_W-1:0]     lg_in;
  logic [NB_W-1:0]     n_blk;
  logic                busy_q;
  logic                accept_start;
  logic                take;
  logic                load_next;
  logic [MAX_N*PW-1:0] above_q;
  logic [MAX_N*PW-1:0] left_q;
  logic [PW-1:0]       corner_q;
  logic [PW-1:0]       dc;
  logic [PW-1:0]       pix_w;
  logic [IDX_W-1:0]    row;
  logic [IDX_W-1:0]    col;
  logic                at_end;

  always_comb begin
    unique case (size_sel)
      2'd0:    lg_in = LG_W'(2);
      2'd1:    lg_in = LG_W'(3);
      default: lg_in = LG_W'(LG_MAX);
    endcase
  end

  assign n_blk        = NB_W'(1) << lg_q;
  assign busy_q       = (st != ST_IDLE);
  assign accept_start = (st == ST_IDLE) && start;
  assign take         = out_valid && out_ready;
  assign load_next    = (st == ST_PREP) || ((st == ST_EMIT) && take && !out_last);

  ip_nbr_store #(.MAX_N(MAX_N), .PW(PW)) u_store (
    .clk(clk), .rst(rst), .load(accept_start),
    .above_i(above), .left_i(left), .corner_i(corner),
    .above_q(above_q), .left_q(left_q), .corner_q(corner_q)
  );

  ip_dc_calc #(.MAX_N(MAX_N), .PW(PW)) u_dc (
    .above_q(above_q), .left_q(left_q), .lg(lg_q), .n_blk(n_blk), .dc(dc)
  );

  ip_raster #(.MAX_N(MAX_N)) u_scan (
    .clk(clk), .rst(rst), .clear(accept_start), .advance(load_next),
    .n_blk(n_blk), .row(row), .col(col), .at_end(at_end)
  );

  ip_pix_gen #(.MAX_N(MAX_N), .PW(PW)) u_gen (
    .mode(mode_q), .row(row), .col(col), .above_q(above_q), .left_q(left_q),
    .corner_q(corner_q), .dc(dc), .pix(pix_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      mode_q <= PM_DC;
      lg_q   <= LG_W'(2);
    end else begin
      unique case (st)
        ST_IDLE: if (start) begin
          st     <= ST_PREP;
          mode_q <= pred_mode_t'(mode_sel);
          lg_q   <= lg_in;
        end
        ST_PREP: st <= ST_EMIT;
        default: if (take && out_last) st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
      out_last  <= 1'b0;
    end else if (load_next) begin
      out_valid <= 1'b1;
      out_pix   <= pix_w;
      out_last  <= at_end;
    end else if (take && out_last) begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
    end
  end
endmodule

// File: rtl/intra_pred_chk.sv
module intra_pred_chk #(
  parameter int PW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          busy,
  input logic          out_ready,
  input logic          out_valid,
  input logic [PW-1:0] out_pix,
  input logic          out_last
);
  AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid); // R6

  AST_DONE_DROPS: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_last) |=> (!out_valid && !busy)); // R6

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pix) && $stable(out_last))); // R7

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !(out_valid && out_ready && out_last)) |=> busy); // R8

  AST_FIRST_BEAT: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (!out_valid ##1 out_valid)); // R11

  AST_VALID_BUSY: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> busy); // R10
endmodule

bind intra_pred intra_pred_chk #(.PW(PW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy_q), .out_ready(out_ready),
  .out_valid(out_valid), .out_pix(out_pix), .out_last(out_last)
);

// File: tb/intra_pred_test.sv
module intra_pred_test;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_N = 16;
  localparam int PW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [1:0] size_sel = '0;
  logic [1:0] mode_sel = '0;
  logic [MAX_N*PW-1:0] above = '0;
  logic [MAX_N*PW-1:0] left = '0;
  logic [PW-1:0] corner = '0;
  logic out_ready = 1'b0;
  logic out_valid;
  logic [PW-1:0] out_pix;
  logic out_last;

  int n_run = 0;
  int n_fail = 0;
  int a_s[MAX_N];
  int l_s[MAX_N];
  int c_s;
  int unsigned seed = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  intra_pred uut (
    .clk(clk), .rst(rst), .start(start), .size_sel(size_sel), .mode_sel(mode_sel),
    .above(above), .left(left), .corner(corner), .out_ready(out_ready),
    .out_valid(out_valid), .out_pix(out_pix), .out_last(out_last)
  );

  function automatic int rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'(seed >> 16);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expect_pix(input int md, input int n, input int i, input int j);
    int s, v, lg2;
    case (md)
      0: begin
        s = 0;
        for (int k = 0; k < n; k++) s += a_s[k] + l_s[k];
        lg2 = (n == 4) ? 3 : (n == 8) ? 4 : 5;
        return (s + n) >> lg2;
      end
      1: return a_s[j];
      2: return l_s[i];
      default: begin
        v = l_s[i] + a_s[j] - c_s;
        if (v < 0) v = 0;
        if (v > 255) v = 255;
        return v;
      end
    endcase
  endfunction

  task automatic run_block(input int sz, input int md, input int pat);
    int n, nn, idx, e, hold;
    string tag;
    n = (sz == 0) ? 4 : (sz == 1) ? 8 : 16;
    nn = n * n;
    tag = (md == 0) ? "R4" : (md == 1) ? "R3" : (md == 2) ? "R2" : "R5";
    for (int k = 0; k < MAX_N; k++) begin
      case (pat)
        0: begin a_s[k] = rnd() & 255; l_s[k] = rnd() & 255; end
        1: begin a_s[k] = 255; l_s[k] = 255 - (k & 1); end
        2: begin a_s[k] = k & 1; l_s[k] = 0; end
        default: begin a_s[k] = (k * 16 + 3) & 255; l_s[k] = 200 - k * 7; end
      endcase
      above[k*PW +: PW] = PW'(a_s[k]);
      left[k*PW +: PW] = PW'(l_s[k]);
    end
    c_s = (pat == 1) ? 0 : (pat == 2) ? 255 : (pat == 3) ? 100 : (rnd() & 255);
    corner = PW'(c_s);
    @(negedge clk);
    start = 1'b1; size_sel = 2'(sz); mode_sel = 2'(md);
    @(negedge clk);
    // second start while busy, and scrambled buses: both must have no effect
    check(out_valid == 1'b0, "R11 valid low one edge after start", int'(out_valid), 0);
    size_sel = 2'(sz + 1); mode_sel = 2'(md + 1);
    above = ~above; left = {left[PW-1:0], left[MAX_N*PW-1:PW]}; corner = ~corner;
    @(negedge clk);
    start = 1'b0;
    check(out_valid == 1'b1, "R11 valid high two edges after start", int'(out_valid), 1);
    idx = 0;
    while (idx < nn) begin
      out_ready = (rnd() % 4) != 0;
      e = expect_pix(md, n, idx / n, idx % n);
      check(out_valid == 1'b1, "R6 valid during block", int'(out_valid), 1);
      check(int'(out_pix) == e, {tag, " R9 R8 pixel value"}, int'(out_pix), e);
      check(out_last == (idx == nn - 1), "R1 R6 last flag position", int'(out_last), int'(idx == nn - 1));
      if (!out_ready) begin
        hold = int'(out_pix);
        @(negedge clk);
        check(out_valid && int'(out_pix) == hold, "R7 stall hold", int'(out_pix), hold);
      end else begin
        @(negedge clk);
        idx++;
      end
    end
    out_ready = 1'b0;
    check(out_valid == 1'b0, "R6 valid low after last", int'(out_valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R10 reset valid", int'(out_valid), 0);
    check(out_last == 1'b0, "R10 reset last", int'(out_last), 0);
    rst = 1'b0;
    @(negedge clk);
    for (int sz = 0; sz < 4; sz++)
      for (int md = 0; md < 4; md++)
        for (int pat = 0; pat < 4; pat++)
          run_block(sz, md, pat);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule